// File: doc/BRIEF.md
# Two-Wire Register Slave with Clock Snapshot Control

This block is the serial front end of a small timekeeping register file. It watches a two-wire (I2C) bus through synchronizers, detects START, repeated START and STOP, answers a fixed 7-bit device address, and gives access to a bank of byte registers through a volatile word pointer. A write transaction loads the pointer from its first data byte and stores any further bytes at successive addresses. A read transaction streams bytes out from the pointer, which moves on each time the master acknowledges a byte.

The lower part of the bank holds the user-visible copy of the live clock. The byte layout is hundredths, seconds, minutes, hours in 24-hour form, then day-of-week, day, month and year. The counters themselves sit outside the block and present a parallel bus plus an update strobe. While a transaction addressed to this device is under way and the pointer sits on a clock byte, the copy is frozen, so a multi-byte read sees one coherent instant. Updates that arrive during the freeze are held. The newest one is applied in a single cycle once the freeze lifts, either on STOP or when the pointer steps into the non-clock range.

Top module: `rtc_i2c_slave`

## Requirements
- R1: A START followed by an address byte whose upper seven bits equal DEV_ADDR is acknowledged (SDA pulled low during the ninth clock). Any other address is not acknowledged and leaves the pointer and registers untouched.
- R2: In a write transaction (address byte bit 0 = 0), the first byte after the address loads the pointer with its low log2(NUM_REGS) bits.
- R3: Each further byte of a write transaction is stored at the pointer, and the pointer then advances by one.
- R4: In a read transaction (address byte bit 0 = 1), the slave drives the byte at the pointer MSB first. The pointer advances by one only when the master acknowledges that byte.
- R5: When the master does not acknowledge a read byte, the slave releases SDA, leaves the pointer unchanged and drives nothing until the next START.
- R6: The pointer wraps from NUM_REGS-1 to 0 when it advances.
- R7: A read that is not preceded by a pointer write starts at the address left in the pointer by the previous transaction. After reset the pointer is 0 and all registers are 0.
- R8: When the copy is not frozen, an update strobe copies live_time byte k (bits 8k+7..8k) into register k for every k below CLK_REGS, visible one cycle later.
- R9: The copy is frozen from the acknowledge of a matching address until STOP, for as long as the pointer is below CLK_REGS. This holds in both read and write transactions.
- R10: Updates received while frozen are held. On STOP the clock registers take the newest held value.
- R11: When the pointer advances from a clock address to CLK_REGS or above without a STOP, the held value is applied at once.
- R12: The slave changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain drive) |
| live_time | input | CLK_REGS*8 | Current timekeeping counter bytes, byte k for register k |
| live_upd | input | 1 | One-cycle strobe: live_time holds a new value |

## Verification
On every cycle, assertions check these properties: the SDA drive moves only with SCL low, a non-acknowledged read byte leaves the pointer in place, a frozen clock copy stays fixed unless the bus writes it, and an unfrozen strobe or a held update lands in the clock bytes one cycle later. Only the bench's transactions show the rest. That covers which address is acknowledged, that data bytes land at the right registers and come back in order across the wrap, and that the current-address read starts where the last transaction stopped. It also covers the distinction between the two ways out of a freeze: a STOP, and a pointer that walks into the non-clock range while the transaction continues through a repeated START.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,   // waiting for START
      ST_ADDR,   // shifting the device address byte
      ST_AACK,   // driving the address acknowledge
      ST_RX,     // receiving a word address or data byte
      ST_RACK,   // driving the acknowledge of a received byte
      ST_TX,     // driving a data byte
      ST_MACK    // sampling the master acknowledge
   } bus_st_t;
endpackage

// File: rtl/rtc_i2c_sync.sv
module rtc_i2c_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_p, sda_p;

   if (STAGES < 1) begin : g_bad
      $error("rtc_i2c_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_one
      logic scl_r, sda_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_r <= 1'b1;
            sda_r <= 1'b1;
         end else begin
            scl_r <= scl_i;
            sda_r <= sda_i;
         end
      end
      assign scl_s = scl_r;
      assign sda_s = sda_r;
   end else begin : g_chain
      logic [STAGES-1:0] scl_sh, sda_sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            scl_sh <= '1;
            sda_sh <= '1;
         end else begin
            scl_sh <= {scl_sh[STAGES-2:0], scl_i};
            sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         end
      end
      assign scl_s = scl_sh[STAGES-1];
      assign sda_s = sda_sh[STAGES-1];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_p <= 1'b1;
         sda_p <= 1'b1;
      end else begin
         scl_p <= scl_s;
         sda_p <= sda_s;
      end
   end

   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/rtc_i2c_fsm.sv
module rtc_i2c_fsm
   import rtc_i2c_pkg::*;
#(
   parameter int         AW       = 4,
   parameter logic [6:0] DEV_ADDR = 7'h3A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_s,
   input  logic          sda_s,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic [7:0]    rd_data,
   output logic [AW-1:0] ptr,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [7:0]    wr_data,
   output logic          busy,
   output logic          sda_oe
);
   bus_st_t    st;
   logic [3:0] bitcnt;
   logic [7:0] shreg;
   logic       rw, first, mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         bitcnt  <= '0;
         shreg   <= '0;
         rw      <= 1'b0;
         first   <= 1'b0;
         mack    <= 1'b0;
         ptr     <= '0;
         wr_en   <= 1'b0;
         wr_addr <= '0;
         wr_data <= '0;
         busy    <= 1'b0;
         sda_oe  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            st     <= ST_IDLE;
            busy   <= 1'b0;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (st)
               ST_IDLE: ;
               ST_ADDR: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     if (shreg[7:1] == DEV_ADDR) begin
                        sda_oe <= 1'b1;
                        rw     <= shreg[0];
                        busy   <= 1'b1;
                        st     <= ST_AACK;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     bitcnt <= '0;
                     if (rw) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        st     <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        first  <= 1'b1;
                        st     <= ST_RX;
                     end
                  end
               end
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     sda_oe <= 1'b1;
                     st     <= ST_RACK;
                     first  <= 1'b0;
                     if (first) begin
                        ptr <= shreg[AW-1:0];
                     end else begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= shreg;
                        ptr     <= ptr + 1'b1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     bitcnt <= '0;
                     st     <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall) begin
                     if (bitcnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        st     <= ST_MACK;
                     end else begin
                        shreg  <= {shreg[6:0], 1'b0};
                        sda_oe <= ~shreg[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                     if (!sda_s) ptr <= ptr + 1'b1;
                  end else if (scl_fall) begin
                     if (mack) begin
                        shreg  <= rd_data;
                        sda_oe <= ~rd_data[7];
                        bitcnt <= '0;
                        st     <= ST_TX;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: st <= ST_IDLE;
            endcase
         end
      end
   end

   // R12: the drive toggles only in the low phase of SCL
   assert_sda_low_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R5: a master NACK leaves the pointer where it was
   assert_nack_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_MACK && scl_rise && sda_s && !stop_det && !start_det) |=> $stable(ptr));

   // R4: the pointer moves only out of the receive or master-ack phases
   assert_ptr_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ptr) |-> ($past(st) == ST_RX || $past(st) == ST_MACK));
endmodule

// File: rtl/rtc_i2c_regs.sv
module rtc_i2c_regs #(
   parameter int NREG = 16,
   parameter int NCLK = 8,
   localparam int AW  = $clog2(NREG),
   localparam int LW  = NCLK * 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          freeze,
   input  logic [LW-1:0] live_time,
   input  logic          live_upd,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [LW-1:0]     hold_q;
   logic              pend_q;
   logic              copy_en;
   logic [LW-1:0]     copy_src;
   logic [LW-1:0]     clk_vec;
   logic [NREG*8-1:0] flat;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_q <= '0;
         pend_q <= 1'b0;
      end else if (live_upd) begin
         hold_q <= live_time;
         pend_q <= freeze;
      end else if (!freeze) begin
         pend_q <= 1'b0;
      end
   end

   assign copy_en  = !freeze && (live_upd || pend_q);
   assign copy_src = live_upd ? live_time : hold_q;

   for (genvar k = 0; k < NREG; k++) begin : g_reg
      logic [7:0] q;
      if (k < NCLK) begin : g_clk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (wr_en && wr_addr == AW'(k))     q <= wr_data;
            else if (copy_en)                        q <= copy_src[8*k +: 8];
         end
         assign clk_vec[8*k +: 8] = q;
      end else begin : g_usr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= '0;
            else if (wr_en && wr_addr == AW'(k))     q <= wr_data;
         end
      end
      assign flat[8*k +: 8] = q;
   end

   assign rd_data = flat[rd_addr*8 +: 8];

   // R9: frozen clock bytes change only through a bus write
   assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (freeze && !wr_en) |=> $stable(clk_vec));

   // R8: an unfrozen strobe lands one cycle later
   assert_live_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (live_upd && !freeze && !wr_en) |=> clk_vec == $past(live_time));

   // R10, R11: a held update is applied as soon as the freeze lifts
   assert_catchup_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !freeze && !live_upd && !wr_en) |=> clk_vec == $past(hold_q));
endmodule

// File: rtl/rtc_i2c_slave.sv
module rtc_i2c_slave #(
   parameter logic [6:0] DEV_ADDR    = 7'h3A,
   parameter int         NUM_REGS    = 16,
   parameter int         CLK_REGS    = 8,
   parameter int         SYNC_STAGES = 2,
   localparam int        AW          = $clog2(NUM_REGS),
   localparam int        LW          = CLK_REGS * 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   output logic          sda_oe,
   input  logic [LW-1:0] live_time,
   input  logic          live_upd
);
   if (NUM_REGS < 2 || NUM_REGS > 256 || (1 << AW) != NUM_REGS) begin : g_chk_nreg
      $error("rtc_i2c_slave: NUM_REGS must be a power of two in 2..256");
   end
   if (CLK_REGS < 1 || CLK_REGS > NUM_REGS) begin : g_chk_nclk
      $error("rtc_i2c_slave: CLK_REGS must lie in 1..NUM_REGS");
   end

   logic          scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [AW-1:0] ptr, wr_addr;
   logic          wr_en, busy, freeze;
   logic [7:0]    wr_data, rd_data;

   rtc_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   rtc_i2c_fsm #(.AW(AW), .DEV_ADDR(DEV_ADDR)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det), .rd_data(rd_data),
      .ptr(ptr), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .sda_oe(sda_oe)
   );

   assign freeze = busy && ({1'b0, ptr} < (AW+1)'(CLK_REGS));

   rtc_i2c_regs #(.NREG(NUM_REGS), .NCLK(CLK_REGS)) u_regs (
      .clk(clk), .rst_n(rst_n), .freeze(freeze),
      .live_time(live_time), .live_upd(live_upd),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(ptr), .rd_data(rd_data)
   );
endmodule

// File: tb/rtc_i2c_slave_tb.sv
module rtc_i2c_slave_tb;
   localparam logic [6:0] DEV = 7'h3A;
   localparam int Q = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic        sda_oe;
   logic [63:0] live_time = '0;
   logic        live_upd = 1'b0;
   wire         sda_line = sda_m & ~sda_oe;

   int          n_chk = 0;
   int          n_fail = 0;
   logic [7:0]  mreg [16];
   logic [3:0]  mptr = '0;

   always #10 clk = ~clk;

   rtc_i2c_slave #(.DEV_ADDR(DEV)) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .live_time(live_time), .live_upd(live_upd)
   );

   function automatic logic [7:0] live_byte(input logic [63:0] v, input int k);
      return v[8*k +: 8];
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
      end
      sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack = ~sda_line; wq(); scl = 1'b0; wq();
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         sda_m = 1'b1; wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0; wq();
      end
      sda_m = ~mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
   endtask

   task automatic pulse(input logic [63:0] v);
      live_time = v; live_upd = 1'b1; @(negedge clk); live_upd = 1'b0;
   endtask

   // pulse while idle: model copy is immediate (R8)
   task automatic pulse_idle(input logic [63:0] v);
      pulse(v);
      for (int k = 0; k < 8; k++) mreg[k] = live_byte(v, k);
   endtask

   task automatic addr_w(input logic [3:0] wa);
      logic a;
      bus_start(); send_byte({DEV, 1'b0}, a); chk("R1 write address ack", {7'd0, a}, 8'd1);
      send_byte({4'd0, wa}, a); chk("R2 word address ack", {7'd0, a}, 8'd1);
      mptr = wa;
   endtask

   task automatic reg_write(input logic [3:0] wa, input int n, input logic [7:0] d [4]);
      logic a;
      addr_w(wa);
      for (int i = 0; i < n; i++) begin
         send_byte(d[i], a); chk("R3 data ack", {7'd0, a}, 8'd1);
         mreg[mptr] = d[i]; mptr = mptr + 4'd1;
      end
      bus_stop();
   endtask

   // n bytes; last is NACKed, so the pointer rests on the last byte read (R5)
   task automatic reg_read(input logic set_addr, input logic [3:0] wa, input int n, input string tag);
      logic a;
      logic [7:0] b;
      if (set_addr) addr_w(wa);
      bus_start(); send_byte({DEV, 1'b1}, a); chk("R1 read address ack", {7'd0, a}, 8'd1);
      for (int i = 0; i < n; i++) begin
         recv_byte(i != n-1, b); chk(tag, b, mreg[mptr]);
         if (i != n-1) mptr = mptr + 4'd1;
      end
      bus_stop();
   endtask

   initial begin
      int wd;
      for (wd = 0; wd < 190000; wd++) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=<190000 cycles", wd);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic a;
      logic [7:0] b;
      logic [7:0] d [4];
      logic [63:0] v1, v2, v3, v4, v5;
      void'($urandom(32'd20240611));
      for (int k = 0; k < 16; k++) mreg[k] = '0;
      repeat (5) @(negedge clk);
      chk("R12 reset releases sda", {7'd0, sda_oe}, 8'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      // R7: reset pointer 0, registers 0
      reg_read(1'b0, 4'd0, 1, "R7 current read after reset");

      // R8: idle strobe copies live bytes
      v1 = 64'h2406_1103_1423_5907;
      pulse_idle(v1);
      reg_read(1'b1, 4'd0, 8, "R8 clock bytes after idle update");

      // R3: write user registers, read back with auto increment (R4)
      d = '{8'hA5, 8'h3C, 8'h00, 8'hFF};
      reg_write(4'd8, 4, d);
      reg_read(1'b1, 4'd8, 4, "R4 sequential readback");

      // R7, R5: current-address read twice, pointer not advanced by NACK
      reg_read(1'b0, 4'd0, 1, "R7 current address read");
      reg_read(1'b0, 4'd0, 1, "R5 pointer held after NACK");

      // R1: foreign address ignored
      bus_start(); send_byte({7'h15, 1'b0}, a); chk("R1 foreign address no ack", {7'd0, a}, 8'd0);
      send_byte(8'h02, a); bus_stop();
      reg_read(1'b0, 4'd0, 1, "R1 pointer untouched by foreign write");

      // R6: wrap 15 -> 0
      reg_read(1'b1, 4'd15, 3, "R6 read across wrap");

      // R9, R10: freeze during read, resume on STOP with newest held value
      v2 = 64'h2406_1103_1424_0001; v3 = 64'h2406_1103_1424_0102;
      addr_w(4'd0);
      bus_start(); send_byte({DEV, 1'b1}, a);
      recv_byte(1'b1, b); chk("R9 byte 0 before update", b, live_byte(v1, 0));
      pulse(v2); pulse(v3);
      for (int k = 1; k < 5; k++) begin
         recv_byte(k != 4, b); chk("R9 frozen read byte", b, live_byte(v1, k));
      end
      bus_stop();
      for (int k = 0; k < 8; k++) mreg[k] = live_byte(v3, k);
      reg_read(1'b1, 4'd0, 8, "R10 newest value after STOP");

      // R9: freeze holds in a write transaction too
      v4 = 64'h2406_1103_1425_1515;
      addr_w(4'd2);
      pulse(v4);
      bus_start(); send_byte({DEV, 1'b1}, a);
      recv_byte(1'b0, b); chk("R9 frozen during write transaction", b, live_byte(v3, 2));
      bus_stop();
      for (int k = 0; k < 8; k++) mreg[k] = live_byte(v4, k);
      reg_read(1'b1, 4'd0, 8, "R10 resume after write transaction");

      // R11: leave clock range without STOP
      v5 = 64'h2406_1203_0001_0203;
      addr_w(4'd6);
      bus_start(); send_byte({DEV, 1'b1}, a);
      recv_byte(1'b1, b); chk("R11 byte 6", b, live_byte(v4, 6));
      pulse(v5);
      recv_byte(1'b1, b); chk("R11 byte 7 still frozen", b, live_byte(v4, 7));
      recv_byte(1'b0, b); chk("R11 byte 8", b, mreg[8]);
      bus_start(); send_byte({DEV, 1'b0}, a); send_byte(8'h00, a);
      bus_start(); send_byte({DEV, 1'b1}, a);
      for (int k = 0; k < 8; k++) begin
         recv_byte(k != 7, b); chk("R11 applied on range exit", b, live_byte(v5, k));
      end
      bus_stop();
      for (int k = 0; k < 8; k++) mreg[k] = live_byte(v5, k);
      mptr = 4'd7;

      // random mix
      for (int it = 0; it < 28; it++) begin
         int op, st, n;
         op = $urandom % 4;
         if (op == 0) begin
            st = 8 + $urandom % 8;
            n = 1 + $urandom % 4;
            if (st + n > 16) n = 16 - st;
            for (int i = 0; i < 4; i++) d[i] = 8'($urandom);
            reg_write(4'(st), n, d);
         end else if (op == 1) begin
            pulse_idle({$urandom, $urandom});
            repeat (2) @(negedge clk);
         end else if (op == 2) begin
            reg_read(1'b1, 4'($urandom), 1 + $urandom % 6, "R4 random read");
         end else begin
            reg_read(1'b0, 4'd0, 1 + $urandom % 3, "R7 random current read");
         end
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule